// File: doc/BRIEF.md
# Tiled Integer Matrix Multiply Sequencer

This block forms the product of a left operand of nr rows by nq columns and a right operand of nq rows by nc columns, and leaves the nr by nc result in a destination array. All three arrays live in local word-addressed memories outside the block. The block generates the read addresses for both operands, a read address for the stored partial result, and the write address and data for the destination. The memories return read data one clock after the address is presented. The arithmetic is a single signed integer multiply-accumulate path.

The iteration space is cut into rectangular tiles. The row, column and inner-dimension tile sizes are inputs chosen for each run. Each tile runs to completion before the next tile begins. A destination element starts from zero when its first inner-dimension tile is processed. Each later inner tile reloads the stored partial sum and adds to it. Any legal tile size gives the same result, so tile sizes equal to the matrix dimensions give the plain untiled product.

A one-cycle `start` launches a run with the configuration present on the inputs. `busy` covers the run, and `done` pulses once after the final destination write. A configuration with a zero dimension or a zero tile size is refused with a one-cycle `err` pulse.

Top module: `mm_tiled_matmul`

## Requirements
- R1: Tiles are visited with column tiles outermost, row tiles next and inner-dimension tiles innermost. Inside a tile, destination elements are visited column by column, and within a column row by row in increasing order.
- R2: A tile spans from its start index to start + size − 1 (0-based), clamped to the last index of that dimension. The next tile of a dimension starts one past the previous tile's last index.
- R3: In the first inner tile (inner start index 0), a destination element's accumulator starts at zero, whatever the memory held before. In every later inner tile it starts from the value read back from the destination.
- R4: For any nonzero tile sizes, including sizes equal to the dimensions, the destination ends holding the exact product, where element (r,c) is the sum over q of left(r,q)·right(q,c).
- R5: Arrays are column-major. Left (r,q) is at base_a + q·nr + r, right (q,c) is at base_b + c·nq + q, and destination (r,c) is at base_d + c·nr + r. No word outside base_d .. base_d + nr·nc − 1 is written.
- R6: A start with any dimension or tile size equal to zero raises `err` for exactly one cycle in the following cycle. The block then stays idle and performs no write.
- R7: `busy` is high from the cycle after an accepted start until `done`. `done` is high for exactly one cycle, in the cycle after the last destination write, and `busy` is low after it.
- R8: Operands are signed DATA_W-bit two's-complement values. The accumulator is 2·DATA_W + DIM_W bits wide, so sums of maximum-magnitude operands over the largest inner dimension are exact.
- R9: Each destination element is written exactly once per inner tile, giving nr·nc·ceil(nq/tile_q) writes per run. No two writes occur in consecutive cycles.
- R10: A `start` received while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Run request, sampled when idle |
| nr | input | DIM_W | Rows of left operand and destination |
| nc | input | DIM_W | Columns of right operand and destination |
| nq | input | DIM_W | Inner dimension |
| tile_r | input | DIM_W | Row tile size |
| tile_c | input | DIM_W | Column tile size |
| tile_q | input | DIM_W | Inner tile size |
| base_a | input | ADDR_W | Base word address of left operand |
| base_b | input | ADDR_W | Base word address of right operand |
| base_d | input | ADDR_W | Base word address of destination |
| a_addr | output | ADDR_W | Left operand read address |
| a_rdata | input | DATA_W | Left operand read data, one cycle after address |
| b_addr | output | ADDR_W | Right operand read address |
| b_rdata | input | DATA_W | Right operand read data, one cycle after address |
| d_raddr | output | ADDR_W | Destination read address (partial sum) |
| d_rdata | input | ACC_W | Destination read data, one cycle after address |
| d_we | output | 1 | Destination write enable |
| d_waddr | output | ADDR_W | Destination write address |
| d_wdata | output | ACC_W | Destination write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | One-cycle configuration refusal pulse |

## Verification
The bound checker watches the handshake and write discipline on every cycle. It checks that done is a single-cycle pulse that follows a write, that writes never fall in back-to-back cycles or during a refusal, that every write lands inside the destination window, that a zero-sized configuration is refused, and that busy holds until done. The tile visiting order, the edge clamping, the clear-or-reload choice per inner tile and the numerical result can only be shown by the bench's runs. The bench sweeps small dimensions against divisible, non-divisible and whole-matrix tile sizes, with destination memory preloaded with junk. It compares the logged write address sequence and the final array against an arithmetic model, and adds refused configurations, a start while busy and extreme operand values.

// File: rtl/mm_pkg.sv
`timescale 1ns/1ps
package mm_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_TILE,
    S_INIT,
    S_LOAD,
    S_RD,
    S_MAC,
    S_WR,
    S_DONE
  } seq_st_t;
endpackage

// File: rtl/mm_tile_end.sv
`timescale 1ns/1ps
// Last index of a tile: start + size - 1, clamped to dim - 1.
module mm_tile_end #(
  parameter int DIM_W = 4
) (
  input  logic [DIM_W-1:0] first,
  input  logic [DIM_W-1:0] size,
  input  logic [DIM_W-1:0] dim,
  output logic [DIM_W-1:0] last
);
  logic [DIM_W:0] sum;
  logic [DIM_W:0] lim;

  always_comb begin
    sum  = {1'b0, first} + {1'b0, size} - {{DIM_W{1'b0}}, 1'b1};
    lim  = {1'b0, dim} - {{DIM_W{1'b0}}, 1'b1};
    last = (sum > lim) ? lim[DIM_W-1:0] : sum[DIM_W-1:0];
  end
endmodule

// File: rtl/mm_addr.sv
`timescale 1ns/1ps
// Column-major word address: base + col * rows + row.
module mm_addr #(
  parameter int DIM_W  = 4,
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DIM_W-1:0]  col,
  input  logic [DIM_W-1:0]  row,
  input  logic [DIM_W-1:0]  rows,
  output logic [ADDR_W-1:0] addr
);
  logic [2*DIM_W-1:0] off;

  always_comb begin
    off  = col * rows;
    addr = base + ADDR_W'(off) + ADDR_W'(row);
  end
endmodule

// File: rtl/mm_mac.sv
`timescale 1ns/1ps
// Signed multiply-accumulate register with load.
module mm_mac #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ACC_W-1:0]  ld_val,
  input  logic              mac_en,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [ACC_W-1:0]  acc
);
  logic signed [2*DATA_W-1:0] prod;
  logic signed [ACC_W-1:0]    acc_nx;

  always_comb begin
    prod   = $signed(a) * $signed(b);
    acc_nx = $signed(acc) + ACC_W'(prod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (ld_en)  acc <= ld_val;
    else if (mac_en) acc <= acc_nx;
  end
endmodule

// File: rtl/mm_tiled_matmul.sv
`timescale 1ns/1ps
module mm_tiled_matmul
  import mm_pkg::*;
#(
  parameter  int DIM_W  = 4,
  parameter  int DATA_W = 8,
  parameter  int ADDR_W = 10,
  localparam int ACC_W  = 2*DATA_W + DIM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  nr,
  input  logic [DIM_W-1:0]  nc,
  input  logic [DIM_W-1:0]  nq,
  input  logic [DIM_W-1:0]  tile_r,
  input  logic [DIM_W-1:0]  tile_c,
  input  logic [DIM_W-1:0]  tile_q,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  input  logic [ADDR_W-1:0] base_d,
  output logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_rdata,
  output logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_rdata,
  output logic [ADDR_W-1:0] d_raddr,
  input  logic [ACC_W-1:0]  d_rdata,
  output logic              d_we,
  output logic [ADDR_W-1:0] d_waddr,
  output logic [ACC_W-1:0]  d_wdata,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int NDIM = 3;   // 0: rows, 1: columns, 2: inner

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rsync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i_n = rsync[1];

  seq_st_t st, st_nx;
  logic [NDIM-1:0][DIM_W-1:0] dim_q, tsz_q, ts_q, ts_nx, te;
  logic [ADDR_W-1:0] ba_q, bb_q, bd_q;
  logic [DIM_W-1:0]  c_q, r_q, q_q, c_nx, r_nx, q_nx;
  logic              cfg_ok, cfg_en, err_q, err_nx, ld_en, mac_en;
  logic [ACC_W-1:0]  ld_val;
  logic [ADDR_W-1:0] dst_addr;

  // Tile last indices, one clamp per dimension.
  for (genvar gi = 0; gi < NDIM; gi++) begin : g_end
    mm_tile_end #(.DIM_W(DIM_W)) u_end (
      .first(ts_q[gi]), .size(tsz_q[gi]), .dim(dim_q[gi]), .last(te[gi])
    );
  end

  mm_addr #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_addr_a (
    .base(ba_q), .col(q_q), .row(r_q), .rows(dim_q[0]), .addr(a_addr));
  mm_addr #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_addr_b (
    .base(bb_q), .col(c_q), .row(q_q), .rows(dim_q[2]), .addr(b_addr));
  mm_addr #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_addr_d (
    .base(bd_q), .col(c_q), .row(r_q), .rows(dim_q[0]), .addr(dst_addr));

  assign ld_val = (ts_q[2] == '0) ? '0 : d_rdata;

  mm_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_i_n), .ld_en(ld_en), .ld_val(ld_val),
    .mac_en(mac_en), .a(a_rdata), .b(b_rdata), .acc(d_wdata));

  assign cfg_ok = (nr != '0) && (nc != '0) && (nq != '0) &&
                  (tile_r != '0) && (tile_c != '0) && (tile_q != '0);
  assign cfg_en = (st == S_IDLE) && start && cfg_ok;

  // Next-state logic.
  always_comb begin
    st_nx  = st;
    ts_nx  = ts_q;
    c_nx   = c_q;
    r_nx   = r_q;
    q_nx   = q_q;
    err_nx = 1'b0;
    ld_en  = 1'b0;
    mac_en = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        if (cfg_ok) begin
          ts_nx = '0;
          st_nx = S_TILE;
        end else begin
          err_nx = 1'b1;
        end
      end
      S_TILE: begin
        c_nx  = ts_q[1];
        r_nx  = ts_q[0];
        st_nx = S_INIT;
      end
      S_INIT: begin
        q_nx  = ts_q[2];
        st_nx = S_LOAD;
      end
      S_LOAD: begin
        ld_en = 1'b1;
        st_nx = S_RD;
      end
      S_RD: st_nx = S_MAC;
      S_MAC: begin
        mac_en = 1'b1;
        if (q_q < te[2]) begin
          q_nx  = q_q + 1'b1;
          st_nx = S_RD;
        end else begin
          st_nx = S_WR;
        end
      end
      S_WR: begin
        st_nx = S_INIT;
        if (r_q < te[0]) begin
          r_nx = r_q + 1'b1;
        end else if (c_q < te[1]) begin
          c_nx = c_q + 1'b1;
          r_nx = ts_q[0];
        end else begin
          st_nx = S_TILE;
          if (te[2] != dim_q[2] - 1'b1) begin
            ts_nx[2] = te[2] + 1'b1;
          end else if (te[0] != dim_q[0] - 1'b1) begin
            ts_nx[2] = '0;
            ts_nx[0] = te[0] + 1'b1;
          end else if (te[1] != dim_q[1] - 1'b1) begin
            ts_nx[2] = '0;
            ts_nx[0] = '0;
            ts_nx[1] = te[1] + 1'b1;
          end else begin
            st_nx = S_DONE;
          end
        end
      end
      S_DONE: st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st    <= S_IDLE;
      ts_q  <= '0;
      c_q   <= '0;
      r_q   <= '0;
      q_q   <= '0;
      err_q <= 1'b0;
    end else begin
      st    <= st_nx;
      ts_q  <= ts_nx;
      c_q   <= c_nx;
      r_q   <= r_nx;
      q_q   <= q_nx;
      err_q <= err_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      dim_q <= '0;
      tsz_q <= '0;
      ba_q  <= '0;
      bb_q  <= '0;
      bd_q  <= '0;
    end else if (cfg_en) begin
      dim_q <= {nq, nc, nr};
      tsz_q <= {tile_q, tile_c, tile_r};
      ba_q  <= base_a;
      bb_q  <= base_b;
      bd_q  <= base_d;
    end
  end

  assign d_raddr = dst_addr;
  assign d_waddr = dst_addr;
  assign d_we    = (st == S_WR);
  assign busy    = (st != S_IDLE);
  assign done    = (st == S_DONE);
  assign err     = err_q;
endmodule

// File: rtl/mm_tiled_matmul_chk.sv
`timescale 1ns/1ps
module mm_tiled_matmul_chk #(
  parameter int DIM_W  = 4,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [DIM_W-1:0]  nr,
  input logic [DIM_W-1:0]  nc,
  input logic [DIM_W-1:0]  nq,
  input logic [DIM_W-1:0]  tile_r,
  input logic [DIM_W-1:0]  tile_c,
  input logic [DIM_W-1:0]  tile_q,
  input logic [ADDR_W-1:0] base_d,
  input logic              d_we,
  input logic [ADDR_W-1:0] d_waddr,
  input logic              busy,
  input logic              done,
  input logic              err
);
  logic bad_cfg;
  int   woff;
  assign bad_cfg = (nr == '0) || (nc == '0) || (nq == '0) ||
                   (tile_r == '0) || (tile_c == '0) || (tile_q == '0);
  assign woff    = int'(d_waddr) - int'(base_d);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(d_we));
  assert_idle_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  assert_write_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    d_we |=> !d_we);
  assert_write_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    d_we |-> (woff >= 0 && woff < int'(nr) * int'(nc)));
  assert_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && bad_cfg) |=> (err && !busy));
  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!d_we && !busy));
endmodule

bind mm_tiled_matmul mm_tiled_matmul_chk #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_mm_tiled_matmul.sv
`timescale 1ns/1ps
module sim_mm_tiled_matmul;
  localparam int DIM_W  = 3;
  localparam int DATA_W = 6;
  localparam int ADDR_W = 8;
  localparam int ACC_W  = 2*DATA_W + DIM_W;
  localparam int BA = 10, BB = 80, BD = 150;
  localparam logic [ACC_W-1:0] JUNK = 15'h5A5A;
  localparam logic [ACC_W-1:0] SENT = 15'h1234;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DIM_W-1:0] nr_i = 3'd1, nc_i = 3'd1, nq_i = 3'd1;
  logic [DIM_W-1:0] tr_i = 3'd1, tc_i = 3'd1, tq_i = 3'd1;
  logic [ADDR_W-1:0] a_addr, b_addr, d_raddr, d_waddr;
  logic [DATA_W-1:0] a_rdata, b_rdata;
  logic [ACC_W-1:0]  d_rdata, d_wdata;
  logic d_we, busy, done, err;

  logic [DATA_W-1:0] mem_a [256];
  logic [DATA_W-1:0] mem_b [256];
  logic [ACC_W-1:0]  mem_d [256];
  logic [ADDR_W-1:0] wr_log [4096];
  int exp_log [512];
  int wr_n = 0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mm_tiled_matmul #(.DIM_W(DIM_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .nr(nr_i), .nc(nc_i), .nq(nq_i),
    .tile_r(tr_i), .tile_c(tc_i), .tile_q(tq_i),
    .base_a(ADDR_W'(BA)), .base_b(ADDR_W'(BB)), .base_d(ADDR_W'(BD)),
    .a_addr(a_addr), .a_rdata(a_rdata), .b_addr(b_addr), .b_rdata(b_rdata),
    .d_raddr(d_raddr), .d_rdata(d_rdata), .d_we(d_we), .d_waddr(d_waddr),
    .d_wdata(d_wdata), .busy(busy), .done(done), .err(err));

  // Memories with one-cycle read latency; write logger.
  always @(posedge clk) begin
    a_rdata <= mem_a[a_addr];
    b_rdata <= mem_b[b_addr];
    d_rdata <= mem_d[d_raddr];
    if (d_we) begin
      mem_d[d_waddr] <= d_wdata;
      wr_log[wr_n % 4096] <= d_waddr;
      wr_n <= wr_n + 1;
    end
  end

  function automatic int va(int r, int q, int s);
    if (s == 99) return -32;
    return ((r*5 + q*11 + s*7) % 64) - 32;
  endfunction
  function automatic int vb(int q, int c, int s);
    if (s == 99) return -32;
    return ((q*3 + c*13 + s*5) % 64) - 32;
  endfunction
  function automatic int imin(int x, int y);
    return (x < y) ? x : y;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(int nr, int nc, int nq, int tr, int tc, int tq, int s, bit poke);
    int n_exp = 0;
    int w0, cyc, mism, sum;
    for (int r = 0; r < nr; r++)
      for (int q = 0; q < nq; q++) mem_a[BA + q*nr + r] = DATA_W'(va(r, q, s));
    for (int c = 0; c < nc; c++)
      for (int q = 0; q < nq; q++) mem_b[BB + c*nq + q] = DATA_W'(vb(q, c, s));
    for (int k = 0; k < nr*nc; k++) mem_d[BD + k] = JUNK;
    mem_d[BD + nr*nc] = SENT;
    mem_d[BD - 1]     = SENT;
    // Expected write order from the tile nest (R1, R2).
    for (int ct = 0; ct < nc; ct += tc)
      for (int rt = 0; rt < nr; rt += tr)
        for (int qt = 0; qt < nq; qt += tq)
          for (int c = ct; c < imin(ct + tc, nc); c++)
            for (int r = rt; r < imin(rt + tr, nr); r++) begin
              exp_log[n_exp] = BD + c*nr + r;
              n_exp++;
            end
    @(negedge clk);
    w0 = wr_n;
    nr_i = DIM_W'(nr); nc_i = DIM_W'(nc); nq_i = DIM_W'(nq);
    tr_i = DIM_W'(tr); tc_i = DIM_W'(tc); tq_i = DIM_W'(tq);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    cyc = 0;
    while (!done && cyc < 20000) begin
      start = poke && (cyc == 5);   // R10: start while busy
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R7 done reached", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7 done single cycle", int'(done), 0);
    chk(wr_n - w0 == n_exp, "R9 R10 write count", wr_n - w0, n_exp);
    mism = 0;
    for (int i = 0; i < imin(n_exp, wr_n - w0); i++)
      if (int'(wr_log[(w0 + i) % 4096]) != exp_log[i]) mism++;
    chk(mism == 0, "R1 R2 write order mismatches", mism, 0);
    for (int c = 0; c < nc; c++)
      for (int r = 0; r < nr; r++) begin
        sum = 0;
        for (int q = 0; q < nq; q++) sum += va(r, q, s) * vb(q, c, s);
        chk(int'($signed(mem_d[BD + c*nr + r])) == sum, "R3 R4 R8 product element",
            int'($signed(mem_d[BD + c*nr + r])), sum);
      end
    chk(mem_d[BD + nr*nc] == SENT, "R5 word after window", int'(mem_d[BD + nr*nc]), int'(SENT));
    chk(mem_d[BD - 1] == SENT, "R5 word before window", int'(mem_d[BD - 1]), int'(SENT));
  endtask

  task automatic err_case(int nr, int nc, int nq, int tr, int tc, int tq);
    int w0;
    mem_d[BD] = SENT;
    @(negedge clk);
    w0 = wr_n;
    nr_i = DIM_W'(nr); nc_i = DIM_W'(nc); nq_i = DIM_W'(nq);
    tr_i = DIM_W'(tr); tc_i = DIM_W'(tc); tq_i = DIM_W'(tq);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R6 err raised, idle", int'(err), 1);
    @(negedge clk);
    chk(err == 1'b0 && busy == 1'b0, "R6 err one cycle", int'(err), 0);
    repeat (4) @(negedge clk);
    chk(wr_n == w0, "R6 no writes", wr_n - w0, 0);
    chk(mem_d[BD] == SENT, "R6 destination untouched", int'(mem_d[BD]), int'(SENT));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int dl [3];
    int tl [3];
    dl = '{1, 3, 5};
    tl = '{1, 2, 7};
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0 && d_we == 0, "R7 reset outputs quiet",
        int'({busy, done, err, d_we}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        for (int k = 0; k < 3; k++)
          for (int t = 0; t < 3; t++)
            run_case(dl[i], dl[j], dl[k], tl[t], tl[t], tl[t], i + 3*j + 9*k, 1'b0);
    run_case(5, 4, 5, 2, 3, 1, 4, 1'b0);
    run_case(4, 5, 3, 3, 1, 2, 6, 1'b0);
    run_case(5, 5, 5, 5, 5, 5, 8, 1'b0);   // R4 whole-matrix tiles
    err_case(3, 3, 3, 2, 0, 2);
    err_case(3, 3, 3, 0, 2, 2);
    err_case(3, 3, 3, 2, 2, 0);
    err_case(0, 3, 3, 2, 2, 2);
    run_case(3, 4, 5, 2, 2, 2, 2, 1'b1);   // R10
    run_case(7, 7, 7, 3, 2, 4, 99, 1'b0);  // R8 extremes, tiled
    run_case(7, 7, 7, 7, 7, 7, 99, 1'b0);  // R8 extremes, untiled
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule